// File: doc/BRIEF.md
# Host Packet Command Decoder with Purge

This block sits between a transaction scheduler and a packet serializer on the host side of a serial bus controller. The scheduler writes a tagged command word into a 36-bit transmit queue, follows it with the packet payload, and strobes `run_pkt`. The decoder pops the command, splits it into endpoint, address, speed, type, toggle and PID fields for the serializer, streams the payload words one per cycle, and returns exactly one completion code for every transaction.

When the serializer reports that the payload has run dry (`underrun`), the decoder raises a one-cycle abort so that the packet is closed with a corrupted CRC. It then enters a purge state. In that state it throws away the remaining queue entries of the broken packet. It stops at the first start-of-packet command, which it leaves in place for the retry, or when the queue is empty. It then reports the underrun to the scheduler. A malformed command word or a queue that stays empty also produce an error completion, so the scheduler is never left waiting.

Top module: `txq_cmd_decoder`

## Requirements
- R1: After reset all output strobes are low and `fifo_rd` stays low while idle, even with entries in the queue.
- R2: `run_pkt` starts a transaction only when idle. A strobe during a transaction causes no extra pop and no extra completion.
- R3: An entry with tag bits [35:32] = 0 is a command. One cycle after it is popped, `hdr_valid` pulses with endpoint = [29:23], address = [22:16], speed = [9:8], type = [7:6], toggle = [5:4] and PID = [3:0]. Reserved bits [31:30] and [15:10] are ignored.
- R4: Payload entries carry tag 1 (data) or tag 2 (final word). `tx_data` = bits [31:0], one word per cycle in queue order. `tx_last` marks the tag-2 word. `fifo_rd` is never high on an empty queue.
- R5: A packet of L words completes with code 0 (success) in the same cycle as `tx_last`, which is L+1 cycles after the cycle in which `run_pkt` was sampled.
- R6: `underrun` high while streaming pops nothing in that cycle, even if a payload word is ready. The next cycle has a single-cycle `tx_abort` with no `tx_valid`.
- R7: After an abort, every entry with a nonzero tag is discarded, one per cycle. Purging stops without a pop at a tag-0 entry or at an empty queue, and then completion code 1 (underrun) is reported.
- R8: If the first entry after `run_pkt` is not a command, it is consumed, no header is issued, and completion code 2 (malformed) is reported one cycle later.
- R9: A tag-0 entry met while streaming is not consumed, and the transaction ends with code 2.
- R10: If the queue stays empty while a command is awaited, code 3 (timeout) is reported after exactly WAIT_LIMIT cycles, with no pop.
- R11: Each transaction yields exactly one completion. `underrun` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_empty | input | 1 | Transmit queue empty |
| fifo_data | input | 36 | Head entry of the queue (show-ahead) |
| fifo_rd | output | 1 | Pop head entry |
| run_pkt | input | 1 | Scheduler strobe: a command is waiting |
| underrun | input | 1 | Serializer ran out of payload |
| hdr_valid | output | 1 | Header fields valid (pulse) |
| hdr_ep | output | 7 | Endpoint |
| hdr_addr | output | 7 | Device address |
| hdr_speed | output | 2 | Endpoint speed |
| hdr_type | output | 2 | Endpoint type |
| hdr_toggle | output | 2 | Data toggle |
| hdr_pid | output | 4 | Packet identifier |
| tx_valid | output | 1 | Payload word valid |
| tx_data | output | 32 | Payload word |
| tx_last | output | 1 | Final payload word |
| tx_abort | output | 1 | End packet with bad CRC |
| done_valid | output | 1 | Completion strobe |
| done_code | output | 2 | 0 ok, 1 underrun, 2 malformed, 3 timeout |

## Verification
The collision that matters is between an underrun and the delivery of a payload word. The hardest case is the final word: it sits at the queue head in the same cycle that `underrun` rises. The bench sweeps the underrun cycle across every word position of packets of one to five words. This includes the cycle of the final word and the cycle just after completion, when the block is already idle. For each position it predicts how many words reach the serializer, whether the abort or the success code appears, and where the read pointer must stop. A second overlap, a `run_pkt` strobe arriving mid-packet with a retry command queued behind, is judged by the pop count and the number of headers.

// File: rtl/txq_cmd_decoder.sv
module txq_cmd_decoder #(
  parameter int WAIT_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fifo_empty,
  input  logic [35:0] fifo_data,
  output logic        fifo_rd,
  input  logic        run_pkt,
  input  logic        underrun,
  output logic        hdr_valid,
  output logic [6:0]  hdr_ep,
  output logic [6:0]  hdr_addr,
  output logic [1:0]  hdr_speed,
  output logic [1:0]  hdr_type,
  output logic [1:0]  hdr_toggle,
  output logic [3:0]  hdr_pid,
  output logic        tx_valid,
  output logic [31:0] tx_data,
  output logic        tx_last,
  output logic        tx_abort,
  output logic        done_valid,
  output logic [1:0]  done_code
);
  localparam int TW = $clog2(WAIT_LIMIT + 1);
  localparam logic [3:0] TAG_CMD = 4'h0;
  localparam logic [3:0] TAG_END = 4'h2;
  localparam logic [1:0] C_OK = 2'd0, C_UNDER = 2'd1, C_BAD = 2'd2, C_TMO = 2'd3;

  typedef enum logic [1:0] {IDLE, FETCH, STREAM, PURGE} state_t;
  state_t st;
  logic [TW-1:0] wait_cnt;

  logic [3:0] tag;
  logic have, is_cmd;
  assign tag    = fifo_data[35:32];
  assign have   = !fifo_empty;
  assign is_cmd = have && (tag == TAG_CMD);

  assign fifo_rd = (st == FETCH  && have) ||
                   (st == STREAM && have && !underrun && !is_cmd) ||
                   (st == PURGE  && have && !is_cmd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      wait_cnt   <= '0;
      hdr_valid  <= 1'b0;
      hdr_ep     <= '0;
      hdr_addr   <= '0;
      hdr_speed  <= '0;
      hdr_type   <= '0;
      hdr_toggle <= '0;
      hdr_pid    <= '0;
      tx_valid   <= 1'b0;
      tx_data    <= '0;
      tx_last    <= 1'b0;
      tx_abort   <= 1'b0;
      done_valid <= 1'b0;
      done_code  <= C_OK;
    end else begin
      hdr_valid  <= 1'b0;
      tx_valid   <= 1'b0;
      tx_last    <= 1'b0;
      tx_abort   <= 1'b0;
      done_valid <= 1'b0;
      case (st)
        IDLE: begin
          if (run_pkt) begin
            st       <= FETCH;
            wait_cnt <= '0;
          end
        end
        FETCH: begin
          if (is_cmd) begin
            hdr_valid  <= 1'b1;
            hdr_ep     <= fifo_data[29:23];
            hdr_addr   <= fifo_data[22:16];
            hdr_speed  <= fifo_data[9:8];
            hdr_type   <= fifo_data[7:6];
            hdr_toggle <= fifo_data[5:4];
            hdr_pid    <= fifo_data[3:0];
            st         <= STREAM;
          end else if (have) begin
            done_valid <= 1'b1;
            done_code  <= C_BAD;
            st         <= IDLE;
          end else if (wait_cnt == TW'(WAIT_LIMIT - 1)) begin
            done_valid <= 1'b1;
            done_code  <= C_TMO;
            st         <= IDLE;
          end else begin
            wait_cnt <= wait_cnt + TW'(1);
          end
        end
        STREAM: begin
          if (underrun) begin
            tx_abort <= 1'b1;
            st       <= PURGE;
          end else if (is_cmd) begin
            done_valid <= 1'b1;
            done_code  <= C_BAD;
            st         <= IDLE;
          end else if (have) begin
            tx_valid <= 1'b1;
            tx_data  <= fifo_data[31:0];
            if (tag == TAG_END) begin
              tx_last    <= 1'b1;
              done_valid <= 1'b1;
              done_code  <= C_OK;
              st         <= IDLE;
            end
          end
        end
        PURGE: begin
          if (!have || is_cmd) begin
            done_valid <= 1'b1;
            done_code  <= C_UNDER;
            st         <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module txq_cmd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fifo_empty,
  input logic [35:0] fifo_data,
  input logic        fifo_rd,
  input logic        hdr_valid,
  input logic        tx_valid,
  input logic        tx_last,
  input logic        tx_abort,
  input logic        done_valid,
  input logic [1:0]  done_code
);
  a_r3_hdr_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> $past(fifo_rd && fifo_data[35:32] == 4'h0));
  a_r4_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);
  a_r5_last_completes: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> (tx_valid && done_valid && done_code == 2'd0));
  a_r6_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_abort);
  a_r6_abort_alone: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (!tx_valid && !done_valid));
  a_r11_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
endmodule

bind txq_cmd_decoder txq_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
  .fifo_rd(fifo_rd), .hdr_valid(hdr_valid), .tx_valid(tx_valid),
  .tx_last(tx_last), .tx_abort(tx_abort), .done_valid(done_valid),
  .done_code(done_code)
);

// File: tb/tb_txq_cmd_decoder.sv
`timescale 1ns/1ps
module tb_txq_cmd_decoder;
  localparam int WL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [35:0] mem [0:255];
  logic [7:0]  wp = 8'd0, rp = 8'd0;
  logic        fifo_empty, fifo_rd;
  logic [35:0] fifo_data;
  logic        run_pkt = 1'b0, underrun = 1'b0;
  logic        hdr_valid, tx_valid, tx_last, tx_abort, done_valid;
  logic [6:0]  hdr_ep, hdr_addr;
  logic [1:0]  hdr_speed, hdr_type, hdr_toggle, done_code;
  logic [3:0]  hdr_pid;
  logic [31:0] tx_data;

  assign fifo_empty = (rp == wp);
  assign fifo_data  = mem[rp];
  always @(posedge clk) if (fifo_rd) rp <= rp + 8'd1;

  txq_cmd_decoder #(.WAIT_LIMIT(WL)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_rd(fifo_rd), .run_pkt(run_pkt), .underrun(underrun),
    .hdr_valid(hdr_valid), .hdr_ep(hdr_ep), .hdr_addr(hdr_addr),
    .hdr_speed(hdr_speed), .hdr_type(hdr_type), .hdr_toggle(hdr_toggle),
    .hdr_pid(hdr_pid), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_abort(tx_abort), .done_valid(done_valid),
    .done_code(done_code));

  int total = 0, bad = 0;
  bit finished = 0;
  int cur_t, hdr_n, tx_n, last_n, abort_n, done_n, done_t;
  logic [1:0]  dcode;
  logic [23:0] hdr_cap;
  logic [31:0] txbuf [0:31];
  logic [31:0] exp_d [0:31];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (hdr_valid) begin
      hdr_n++;
      hdr_cap = {hdr_ep, hdr_addr, hdr_speed, hdr_type, hdr_toggle, hdr_pid};
    end
    if (tx_valid) begin
      if (tx_n < 32) txbuf[tx_n] = tx_data;
      tx_n++;
      if (tx_last) last_n++;
    end
    if (tx_abort) abort_n++;
    if (done_valid) begin
      done_n++;
      dcode  = done_code;
      done_t = cur_t;
    end
  endtask

  task automatic push(input logic [35:0] w);
    mem[wp] = w;
    wp = wp + 8'd1;
  endtask

  function automatic logic [35:0] mk_cmd(input int n);
    logic [6:0] ep, ad;
    ep = 7'((n * 11) % 128);
    ad = 7'((n * 37) % 128);
    return {4'h0, 2'(n), ep, ad, 6'(n * 5), 2'((n / 4) % 4), 2'((n / 3) % 4), 2'(n % 4), 4'(n % 16)};
  endfunction

  function automatic logic [23:0] exp_hdr(input int n);
    logic [35:0] c;
    c = mk_cmd(n);
    return {c[29:23], c[22:16], c[9:8], c[7:6], c[5:4], c[3:0]};
  endfunction

  task automatic push_pkt(input int n, input int len);
    push(mk_cmd(n));
    for (int i = 0; i < len; i++) begin
      exp_d[i] = 32'h9E37_79B9 * (n + 1) + 32'h0101_0101 * i;
      push({(i == len - 1) ? 4'h2 : 4'h1, exp_d[i]});
    end
  endtask

  task automatic run_txn(input int k, input bit poke);
    hdr_n = 0; tx_n = 0; last_n = 0; abort_n = 0; done_n = 0; done_t = -99;
    run_pkt = 1'b1; underrun = 1'b0; cur_t = -1;
    step();
    run_pkt = 1'b0;
    for (int t = 0; t < 90; t++) begin
      cur_t = t;
      underrun = (t == k + 1);
      run_pkt  = poke && (t == 1);
      step();
      if (done_n > 0 && t >= done_t + 3 && t > k + 2) break;
    end
    underrun = 1'b0;
    run_pkt  = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] r0;
    n = 0;
    cur_t = -1; hdr_n = 0; tx_n = 0; last_n = 0; abort_n = 0; done_n = 0; done_t = 0;
    repeat (3) step();
    rst_n = 1'b1;
    // R1: reset state and no pops while idle
    chk(!hdr_valid && !tx_valid && !tx_abort && !done_valid, "R1 strobes", {hdr_valid, tx_valid, tx_abort, done_valid}, 0);
    push(mk_cmd(0));
    r0 = rp;
    for (int i = 0; i < 4; i++) begin
      step();
      chk(!fifo_rd && !done_valid, "R1 idle pop", {fifo_rd, done_valid}, 0);
    end
    chk(rp == r0, "R1 rp", rp, r0);
    rp = wp;

    // Sweep: length x underrun position x trailing retry command
    for (int len = 1; len <= 5; len++) begin
      for (int k = -1; k <= len; k++) begin
        for (int tr = 0; tr < 2; tr++) begin
          bit uflag;
          n++;
          r0 = rp;
          push_pkt(n, len);
          if (tr == 1) begin
            push(mk_cmd(n + 500));
            push({4'h2, 32'hC0DE_0000 + 32'(n)});
          end
          uflag = (k >= 0 && k < len);
          run_txn(k, tr == 1 && len >= 2);
          chk(hdr_n == 1, "R3 hdr count", hdr_n, 1);
          chk(hdr_cap == exp_hdr(n), "R3 fields", hdr_cap, exp_hdr(n));
          chk(done_n == 1, "R11 one completion", done_n, 1);
          chk(8'(rp - r0) == 8'(1 + len), "R7 R2 pops", 8'(rp - r0), 1 + len);
          if (!uflag) begin
            chk(tx_n == len && last_n == 1, "R4 words", tx_n, len);
            for (int i = 0; i < len; i++)
              chk(txbuf[i] == exp_d[i], "R4 data", txbuf[i], exp_d[i]);
            chk(dcode == 2'd0 && done_t == len, "R5 ok timing", {dcode, 8'(done_t)}, {2'd0, 8'(len)});
            chk(abort_n == 0, "R11 idle underrun", abort_n, 0);
          end else begin
            chk(tx_n == k && last_n == 0, "R6 words before abort", tx_n, k);
            for (int i = 0; i < k; i++)
              chk(txbuf[i] == exp_d[i], "R6 data", txbuf[i], exp_d[i]);
            chk(abort_n == 1, "R6 abort", abort_n, 1);
            chk(dcode == 2'd1 && done_t == len + 2, "R7 underrun code", {dcode, 8'(done_t)}, {2'd1, 8'(len + 2)});
          end
          if (tr == 1) begin
            run_txn(-5, 1'b0);
            chk(hdr_cap == exp_hdr(n + 500) && dcode == 2'd0, "R7 retry kept", hdr_cap, exp_hdr(n + 500));
            chk(tx_n == 1 && txbuf[0] == 32'hC0DE_0000 + 32'(n), "R7 retry data", txbuf[0], 32'hC0DE_0000 + 32'(n));
          end
          chk(rp == wp, "R7 queue drained", rp, wp);
        end
      end
    end

    // R8: every non-command tag as first entry
    for (int tg = 1; tg < 16; tg++) begin
      r0 = rp;
      push({4'(tg), 32'hBAD0_0000 + 32'(tg)});
      run_txn(-5, 1'b0);
      chk(dcode == 2'd2 && done_t == 0 && hdr_n == 0 && tx_n == 0, "R8 malformed", {dcode, 8'(done_t)}, {2'd2, 8'd0});
      chk(8'(rp - r0) == 8'd1, "R8 one pop", 8'(rp - r0), 1);
    end

    // R9: command in the middle of a payload
    n++;
    r0 = rp;
    push(mk_cmd(n));
    push({4'h1, 32'h1234_5678});
    push_pkt(n + 1, 1);
    run_txn(-5, 1'b0);
    chk(dcode == 2'd2 && done_t == 2 && tx_n == 1, "R9 code", {dcode, 8'(done_t)}, {2'd2, 8'd2});
    chk(8'(rp - r0) == 8'd2, "R9 not consumed", 8'(rp - r0), 2);
    run_txn(-5, 1'b0);
    chk(dcode == 2'd0 && hdr_cap == exp_hdr(n + 1), "R9 follow-on", hdr_cap, exp_hdr(n + 1));

    // R10: empty queue timeout
    r0 = rp;
    run_txn(-5, 1'b0);
    chk(dcode == 2'd3 && done_t == WL - 1, "R10 timeout", {dcode, 8'(done_t)}, {2'd3, 8'(WL - 1)});
    chk(rp == r0 && done_n == 1, "R10 no pop", rp, r0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule